// File: doc/BRIEF.md
# Programmable Skew Clock Fanout

This block builds four pairs of clock outputs from one fast clock. The fast clock runs at sixteen times the nominal output frequency, so one fast-clock cycle is one skew unit. Each pair has a six-bit select made of three three-level digits. The select gives the pair one of these behaviours:
- a phase shift of -7 to +7 units against the zero-skew output;
- the complement of the zero-skew output;
- the zero-skew output divided by two or by four;
- a fixed park level.

All pairs are taken from one shared tap line, so their relative phases are exact to the cycle.

A gate input stops every pair except the third (index 2). The exempt pair keeps running, so it can serve as the feedback or reference copy. A pair stops and restarts only at the edge where its own waveform enters the park level, so gating never makes a short pulse. The park level is the complement of the edge-select input.

The edge-select input also picks which edge of the zero-skew waveform advances the dividers. In test mode the internally made clock is replaced by the sampled `ref_i` input, and the same skews still apply.

Top module: `skew_clk_fanout`

## Requirements
- R1: Digits are encoded 00 = low, 01 = mid, 10 = high. Bits [5:4] are digit 2, [3:2] are digit 1 and [1:0] are digit 0. Let v = 9*d2 + 3*d1 + d0, with low=0, mid=1, high=2. Codes with v from 6 (low,high,low) to 20 (high,low,high) give skew s = v - 13. A pair with skew s equals the zero-skew (mid,mid,mid) output s cycles earlier: positive s is later. Both outputs of a pair are equal.
- R2: The digit value 11 reads as mid. A select of all ones behaves as zero skew.
- R3: With `test_i` low, the zero-skew output has a 16-cycle period and is high for 8 cycles.
- R4: Code (high,mid,low) gives the complement of the zero-skew output in the same cycle.
- R5: Code (high,mid,mid) toggles exactly in the cycles where the zero-skew output shows the selected edge: rising when `edge_sel_i`=1, falling when 0. Code (high,mid,high) toggles on every second of those edges, and it rises only in cycles where the divide-by-two output also rises.
- R6: Code (low,low,low) holds the pair at the park level, which is the complement of `edge_sel_i`.
- R7: Every code not named in R1, R4, R5 or R6 holds the pair at the park level.
- R8: With `gate_i` high, every pair except index 2 settles at the park level, while pair 2 keeps toggling. With `gate_i` low again, the gated pairs resume toggling.
- R9: While `gate_i` is toggled, no output of a skew-mode pair has a high or low pulse shorter than 8 cycles.
- R10: With `test_i` high, the source is the sampled `ref_i`. Outputs then have the period of `ref_i` and keep the R1 skew relations.
- R11: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, one cycle per skew unit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | External reference, used as the source in test mode |
| test_i | input | 1 | Selects `ref_i` as the source instead of the internal divider |
| edge_sel_i | input | 1 | Edge used by the dividers; its complement is the park level |
| gate_i | input | 1 | Synchronous stop of all pairs except index 2 |
| sel_i | input | 4x6 | Per-pair three-digit select |
| clk_o | output | 4x2 | Output pairs |

## Verification
The collision of interest is a gate change against each pair's own waveform: gating is released or applied in an arbitrary cycle relative to pairs running at different skews. The bench raises and drops `gate_i` at odd cycle offsets while three pairs sit at zero, +3 and -5 units. It does this once for each edge polarity. It judges the result by measuring every high and low run on those pairs, which must never drop below half a period. It also checks that the gated pairs settle at the correct park level and that the exempt pair never stops.

// File: rtl/skew_clk_pkg.sv
package skew_clk_pkg;
  localparam int SEL_W = 6;
  localparam int SKEW_W = 5;
  localparam int SKEW_MAX = 7;

  typedef enum logic [2:0] {M_PARK, M_SKEW, M_INV, M_DIV2, M_DIV4} mode_e;

  typedef struct packed {
    mode_e mode;
    logic [SKEW_W-1:0] skew;  // two's complement
  } pair_cfg_t;

  function automatic logic [1:0] trit(input logic [1:0] d);
    return (d == 2'b11) ? 2'b01 : d;
  endfunction

  function automatic pair_cfg_t decode_sel(input logic [SEL_W-1:0] c);
    pair_cfg_t r;
    int idx;
    idx = 9 * int'(trit(c[5:4])) + 3 * int'(trit(c[3:2])) + int'(trit(c[1:0]));
    r.mode = M_PARK;
    r.skew = '0;
    if (idx >= 13 - SKEW_MAX && idx <= 13 + SKEW_MAX) begin
      r.mode = M_SKEW;
      r.skew = SKEW_W'(idx - 13);
    end else if (idx == 21) r.mode = M_INV;
    else if (idx == 22) r.mode = M_DIV2;
    else if (idx == 23) r.mode = M_DIV4;
    return r;
  endfunction
endpackage

// File: rtl/skew_clk_timebase.sv
module skew_clk_timebase #(
  parameter int PERIOD   = 16,
  parameter int MAX_SKEW = skew_clk_pkg::SKEW_MAX,
  localparam int DEPTH   = 2 * MAX_SKEW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             test_i,
  input  logic             edge_sel_i,
  output logic [DEPTH-1:0] taps_o,
  output logic             div2_o,
  output logic             div4_o
);
  localparam int PW = $clog2(PERIOD);

  logic [PW-1:0] cnt_q;
  logic [1:0]    ref_sync_q;
  logic          int_clk, src;
  logic [DEPTH-1:0] dl_q;
  logic [1:0]    div_q;
  logic          step;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else cnt_q <= (cnt_q == PW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ref_sync_q <= '0;
    else ref_sync_q <= {ref_sync_q[0], ref_i};

  assign int_clk = (cnt_q < PW'(PERIOD / 2));
  assign src = test_i ? ref_sync_q[1] : int_clk;

  // tap MAX_SKEW is the zero-skew point
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) dl_q <= '0;
    else dl_q <= {dl_q[DEPTH-2:0], src};

  assign taps_o = dl_q;

  // look one tap ahead so divider edges land with the zero-skew tap
  assign step = edge_sel_i ? (dl_q[MAX_SKEW-1] & ~dl_q[MAX_SKEW])
                           : (~dl_q[MAX_SKEW-1] & dl_q[MAX_SKEW]);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) div_q <= '0;
    else if (step) div_q <= div_q + 1'b1;

  assign div2_o = ~div_q[0];
  assign div4_o = ~div_q[1];

  p_div_rise_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div4_o) |-> $rose(div2_o));
endmodule

// File: rtl/skew_clk_pair.sv
module skew_clk_pair
  import skew_clk_pkg::*;
#(
  parameter int MAX_SKEW = SKEW_MAX,
  parameter int NOUT     = 2,
  parameter bit EXEMPT   = 1'b0,
  localparam int DEPTH   = 2 * MAX_SKEW + 1,
  localparam int TW      = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] taps_i,
  input  logic             div2_i,
  input  logic             div4_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             gate_i,
  input  logic             edge_sel_i,
  output logic [NOUT-1:0]  clk_o
);
  pair_cfg_t cfg;
  logic [TW-1:0] tap_sel;
  logic park, raw, raw_q, boundary, stop_q, out_nxt;

  assign cfg = decode_sel(sel_i);
  assign park = ~edge_sel_i;
  assign tap_sel = TW'(MAX_SKEW + int'($signed(cfg.skew)));

  always_comb begin
    unique case (cfg.mode)
      M_SKEW:  raw = taps_i[tap_sel];
      M_INV:   raw = ~taps_i[MAX_SKEW];
      M_DIV2:  raw = div2_i;
      M_DIV4:  raw = div4_i;
      default: raw = park;
    endcase
  end

  // a period boundary is the edge where the waveform enters the park level
  assign boundary = (raw == park) && (raw_q != park);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) raw_q <= 1'b0;
    else raw_q <= raw;

  generate
    if (EXEMPT) begin : g_free
      assign stop_q = 1'b0;
    end else begin : g_gated
      logic stop_r;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stop_r <= 1'b0;
        else if (boundary) stop_r <= gate_i;
      assign stop_q = stop_r;
    end
  endgenerate

  assign out_nxt = (cfg.mode == M_PARK || stop_q) ? park : raw;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) clk_o <= '0;
    else clk_o <= {NOUT{out_nxt}};

  p_stop_at_park_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(stop_q) |-> clk_o == {NOUT{$past(park)}});
  p_stopped_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |=> clk_o == {NOUT{$past(park)}});
  p_park_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode == M_PARK) |=> clk_o == {NOUT{$past(park)}});
endmodule

// File: rtl/skew_clk_fanout.sv
module skew_clk_fanout
  import skew_clk_pkg::*;
#(
  parameter int NPAIRS      = 4,
  parameter int NOUT        = 2,
  parameter int PERIOD      = 16,
  parameter int EXEMPT_PAIR = 2,
  localparam int DEPTH      = 2 * SKEW_MAX + 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ref_i,
  input  logic                             test_i,
  input  logic                             edge_sel_i,
  input  logic                             gate_i,
  input  logic [NPAIRS-1:0][SEL_W-1:0]     sel_i,
  output logic [NPAIRS-1:0][NOUT-1:0]      clk_o
);
  logic [DEPTH-1:0] taps;
  logic div2, div4;

  skew_clk_timebase #(.PERIOD(PERIOD), .MAX_SKEW(SKEW_MAX)) u_tb (
    .clk_i, .rst_ni, .ref_i, .test_i, .edge_sel_i,
    .taps_o(taps), .div2_o(div2), .div4_o(div4)
  );

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    skew_clk_pair #(.MAX_SKEW(SKEW_MAX), .NOUT(NOUT), .EXEMPT(p == EXEMPT_PAIR)) u_pair (
      .clk_i, .rst_ni, .taps_i(taps), .div2_i(div2), .div4_i(div4),
      .sel_i(sel_i[p]), .gate_i, .edge_sel_i, .clk_o(clk_o[p])
    );
  end

  p_reset_low_r11: assert property (@(posedge clk_i) !rst_ni |-> clk_o == '0);
endmodule

// File: tb/skew_clk_fanout_tb_top.sv
module skew_clk_fanout_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0, ref_i = 1'b0, test_i = 1'b0, edge_sel_i = 1'b1, gate_i = 1'b0;
  logic [3:0][5:0] sel_i;
  logic [3:0][1:0] clk_o;
  logic [15:0] hist [4];
  int n_chk = 0, n_err = 0, ref_ctr = 0;
  int run [4];
  bit seen [4];
  int runt = 0;

  always #10 clk = ~clk;  // 50 MHz with 1 ns units

  skew_clk_fanout dut_i (.clk_i(clk), .rst_ni, .ref_i, .test_i, .edge_sel_i, .gate_i, .sel_i, .clk_o);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] scode(input int s);
    int i;
    i = s + 13;
    return {2'(i / 9), 2'((i / 3) % 3), 2'(i % 3)};
  endfunction

  task automatic step();
    @(negedge clk);
    ref_ctr++;
    ref_i = ((ref_ctr % 10) < 5);
    for (int p = 0; p < 4; p++) hist[p] = {hist[p][14:0], clk_o[p][0]};
  endtask

  task automatic track_runs();
    for (int p = 0; p < 4; p++) begin
      if (hist[p][0] != hist[p][1]) begin
        if (seen[p] && run[p] < 8) runt++;
        seen[p] = 1'b1;
        run[p] = 1;
      end else run[p]++;
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    sel_i = {4{6'b010101}};
    repeat (3) @(negedge clk);
    chk(clk_o == '0, "R11 reset outputs", int'(clk_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_skew(input int a, input int b, input int c, input bit all11, input string tag);
    int sk[4];
    int bad[4];
    sk = '{a, b, 0, c};
    bad = '{0, 0, 0, 0};
    sel_i[0] = scode(a);
    sel_i[1] = scode(b);
    sel_i[3] = scode(c);
    sel_i[2] = all11 ? 6'h3F : scode(0);
    repeat (40) step();
    for (int t = 0; t < 48; t++) begin
      step();
      for (int p = 0; p < 4; p++) begin
        if (clk_o[p][1] != clk_o[p][0]) bad[p]++;
        if (p == 2) continue;
        if (sk[p] >= 0) begin
          if (hist[p][0] != hist[2][sk[p]]) bad[p]++;
        end else if (hist[2][0] != hist[p][-sk[p]]) bad[p]++;
      end
    end
    for (int p = 0; p < 4; p++) chk(bad[p] == 0, tag, bad[p], 0);
  endtask

  task automatic t_period(input int exp_per, input string tag);
    int per, hi;
    per = 0;
    hi = 0;
    do step(); while (!(hist[2][0] && !hist[2][1]));
    do begin
      per++;
      if (hist[2][0]) hi++;
      step();
    end while (!(hist[2][0] && !hist[2][1]) && per < 100);
    chk(per == exp_per, {tag, " period"}, per, exp_per);
    chk(hi == exp_per / 2, {tag, " high time"}, hi, exp_per / 2);
  endtask

  task automatic t_div(input bit e);
    int bad_inv, bad_d2, bad_d4, n2, n4;
    bit r, rp, sel_edge, d2c, d4c;
    bad_inv = 0; bad_d2 = 0; bad_d4 = 0; n2 = 0; n4 = 0;
    edge_sel_i = e;
    sel_i[0] = 6'b100100;  // high,mid,low
    sel_i[1] = 6'b100101;  // high,mid,mid
    sel_i[3] = 6'b100110;  // high,mid,high
    sel_i[2] = scode(0);
    repeat (40) step();
    for (int t = 0; t < 64; t++) begin
      step();
      r = hist[2][0];
      rp = hist[2][1];
      sel_edge = e ? (r && !rp) : (!r && rp);
      d2c = hist[1][0] != hist[1][1];
      d4c = hist[3][0] != hist[3][1];
      if (hist[0][0] == r) bad_inv++;
      if (d2c != sel_edge) bad_d2++;
      if (d4c && !d2c) bad_d4++;
      if ((hist[3][0] && !hist[3][1]) && !(hist[1][0] && !hist[1][1])) bad_d4++;
      n2 += int'(d2c);
      n4 += int'(d4c);
    end
    chk(bad_inv == 0, "R4 inverted output", bad_inv, 0);
    chk(bad_d2 == 0, "R5 divide-by-2 edge", bad_d2, 0);
    chk(bad_d4 == 0, "R5 divide-by-4 alignment", bad_d4, 0);
    chk(n4 * 2 == n2, "R5 divide-by-4 rate", n4 * 2, n2);
  endtask

  task automatic t_park(input bit e);
    int bad6, bad7;
    bad6 = 0; bad7 = 0;
    edge_sel_i = e;
    sel_i[0] = 6'b000000;
    sel_i[1] = 6'b000010;
    sel_i[3] = 6'b101010;
    repeat (4) step();
    for (int t = 0; t < 20; t++) begin
      step();
      if (clk_o[0] != {2{~e}}) bad6++;
      if (clk_o[1] != {2{~e}} || clk_o[3] != {2{~e}}) bad7++;
    end
    chk(bad6 == 0, "R6 disabled pair level", bad6, 0);
    chk(bad7 == 0, "R7 reserved code level", bad7, 0);
  endtask

  task automatic t_gate(input bit e);
    int bad_lvl, free_tog, resume_tog;
    bad_lvl = 0; free_tog = 0; resume_tog = 0; runt = 0;
    edge_sel_i = e;
    sel_i[0] = scode(0);
    sel_i[1] = scode(3);
    sel_i[3] = scode(-5);
    sel_i[2] = scode(0);
    repeat (40) step();
    for (int p = 0; p < 4; p++) begin run[p] = 0; seen[p] = 1'b0; end
    repeat (37) begin step(); track_runs(); end
    gate_i = 1'b1;
    for (int t = 0; t < 70; t++) begin
      step();
      track_runs();
      if (t >= 50) begin
        if (clk_o[0] != {2{~e}} || clk_o[1] != {2{~e}} || clk_o[3] != {2{~e}}) bad_lvl++;
        if (hist[2][0] != hist[2][1]) free_tog++;
      end
    end
    repeat (5 + int'(e) * 6) begin step(); track_runs(); end
    gate_i = 1'b0;
    for (int t = 0; t < 60; t++) begin
      step();
      track_runs();
      if (hist[1][0] != hist[1][1]) resume_tog++;
    end
    chk(bad_lvl == 0, "R8 gated pairs at park", bad_lvl, 0);
    chk(free_tog > 0, "R8 exempt pair runs", free_tog, 1);
    chk(resume_tog > 0, "R8 gated pair resumes", resume_tog, 1);
    chk(runt == 0, "R9 no short pulse", runt, 0);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) hist[p] = '0;
    t_reset();
    t_skew(-7, 7, 0, 1'b0, "R1 skew extremes");
    t_skew(-7, 7, 2, 1'b1, "R2 all-ones mid reference");
    t_skew(-1, 3, -4, 1'b0, "R1 skew mid codes");
    t_skew(5, -6, 1, 1'b0, "R1 skew mixed");
    t_period(16, "R3");
    t_div(1'b1);
    t_div(1'b0);
    t_park(1'b1);
    t_park(1'b0);
    t_gate(1'b1);
    t_gate(1'b0);
    edge_sel_i = 1'b1;
    test_i = 1'b1;
    t_skew(2, -3, 7, 1'b0, "R10 bypass skew");
    t_period(10, "R10 bypass");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule